// File: doc/BRIEF.md
# Serial EEPROM Subsystem ID Loader

This block fills two 16-bit identification registers, a subsystem vendor ID and a subsystem ID, once after reset. Two active-low strap inputs are captured while reset is held, and they choose between two modes. In software mode the block stays passive. Firmware drives the two general-purpose open-drain pins directly and may write either ID register. In autoload mode the block acts as a two-wire bus master. It fetches five bytes from the top of a serial EEPROM, verifies a seeded 8-bit checksum, and commits the ID bytes only when the whole transfer and the checksum are good.

In autoload mode the ID registers are read-only. Both stay zero unless the load succeeds. A missing device, a refused word address or a checksum mismatch all leave them at zero. `busy` and `done` report the progress of the one-shot sequence. `loadOk` tells whether the committed values came from the EEPROM.

The serial clock is derived from the system clock. One quarter of a bus bit lasts `QTR_CYC` system clocks.

Top module: `seeprom_id_loader`

## Requirements
- R1: `strapN` is captured only while `rstN` is low. Autoload mode is selected when both straps read 0. Every other strap value selects software mode. Changing the straps after reset has no effect.
- R2: In software mode `pinDriveLow` equals `fwDriveLow` combinationally, and `busy` and `done` stay 0.
- R3: In software mode both ID registers are 0 after reset. A cycle with `wrEn`=1 writes `wrData` into the subsystem ID when `wrSel`=1, or into the vendor ID when `wrSel`=0. The new value is visible from the next cycle.
- R4: In autoload mode `busy` is 1 from reset release until the sequence ends. Then `busy` falls, `done` rises and `done` stays 1 until the next reset.
- R5: The transfer uses pin 0 as the serial clock and pin 1 as the serial data line. It runs start, byte A0h, byte FBh, repeated start, byte A1h, then five read bytes. The master acknowledges the first four read bytes and not the fifth, then sends stop.
- R6: The bytes read from FBh, FCh, FDh and FEh become vendor ID bits 7:0, vendor ID bits 15:8, subsystem ID bits 7:0 and subsystem ID bits 15:8.
- R7: The load is accepted, with `loadOk`=1, only when 55h plus the five bytes read (FBh..FFh) sums to 00h modulo 256. Otherwise both IDs are 0 and `loadOk` is 0.
- R8: A missing acknowledge after the device address or the word address stops the read phase. The master sends stop and ends the sequence with both IDs 0 and `loadOk`=0.
- R9: In autoload mode `wrEn` never changes the ID registers, and both read 0 while `busy` is 1.
- R10: Once `done` is 1, the block drives neither pin low.
- R11: Each serial clock high phase of the bus lasts 2*`QTR_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; straps are captured while low |
| strapN | input | 2 | Mode straps, active low |
| dataPinIn | input | 1 | Level seen on the serial data pin (pin 1) |
| fwDriveLow | input | 2 | Firmware pin pull-down requests, used in software mode |
| pinDriveLow | output | 2 | Open-drain pull-down enables: bit 0 is the clock pin, bit 1 is the data pin |
| wrEn | input | 1 | ID register write strobe, honoured in software mode only |
| wrSel | input | 1 | 0 selects the vendor ID, 1 selects the subsystem ID |
| wrData | input | 16 | Write data |
| vendorId | output | 16 | Subsystem vendor ID register |
| subsysId | output | 16 | Subsystem ID register |
| busy | output | 1 | Autoload sequence in progress |
| done | output | 1 | Autoload sequence finished, whether it passed or failed |
| loadOk | output | 1 | IDs were loaded from a verified EEPROM image |

## Verification
The bench builds the loader with `QTR_CYC` = 3. A complete five-byte fetch then takes about a thousand cycles, so dozens of separate resets fit into one run. These cover a good image, a corrupted checksum, an all-zero image, an absent device, a refused word address and randomly generated images. The short quarter also keeps the measured clock-high width small enough to compare exactly against 2*`QTR_CYC`. The bench's open-drain EEPROM model records the address bytes and the acknowledge pattern that the master produces.

// File: rtl/seeid_pkg.sv
package seeid_pkg;
  localparam logic [6:0] DEV_ADDR  = 7'h50;
  localparam logic [7:0] BASE_ADDR = 8'hFB;
  localparam logic [7:0] SUM_SEED  = 8'h55;
  localparam int         NUM_BYTES = 5;
  localparam int         ID_BYTES  = NUM_BYTES - 1;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } busOp_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       txLoad;
    logic [1:0] txSel;    // 0: device write, 1: word address, 2: device read
    logic       txShift;
    logic       rxShift;
    logic       byteDone;
    logic [2:0] byteIdx;
    logic       finish;
    logic       linkOk;
  } strobe_t;
endpackage

// File: rtl/seeid_ctrl.sv
module seeid_ctrl
  import seeid_pkg::*;
#(
  parameter int QTR_CYC = 125
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    autoMode,
  input  logic    sdaIn,
  input  logic    txBit,
  output strobe_t strb,
  output logic    sclLow,
  output logic    sdaLow,
  output logic    busy,
  output logic    done
);
  localparam int               DIV_W         = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST      = DIV_W'(QTR_CYC - 1);
  localparam logic [3:0]       STEP_FIRST_RD = 4'd5;
  localparam logic [3:0]       STEP_LAST_RD  = 4'(5 + NUM_BYTES - 1);
  localparam logic [3:0]       STEP_STOP     = 4'(5 + NUM_BYTES);
  localparam logic [3:0]       LAST_BIT      = 4'd8;

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       quarter;
  logic [3:0]       bitIdx;
  logic [3:0]       step;
  logic             doneReg;
  logic             nackSeen;
  logic             running;
  logic             tick;
  logic             bitOp;
  logic             opEnd;
  busOp_e           curOp;

  function automatic busOp_e opOf(input logic [3:0] s);
    if (s == 4'd0 || s == 4'd3)     return OP_START;
    else if (s == STEP_STOP)        return OP_STOP;
    else if (s >= STEP_FIRST_RD)    return OP_READ;
    else                            return OP_WRITE;
  endfunction

  always_comb begin
    running = autoMode && !doneReg;
    curOp   = opOf(step);
    bitOp   = (curOp == OP_WRITE) || (curOp == OP_READ);
    tick    = running && (divCnt == DIV_LAST);
    opEnd   = tick && (quarter == 2'd3) && (!bitOp || bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      quarter  <= '0;
      bitIdx   <= '0;
      step     <= '0;
      doneReg  <= 1'b0;
      nackSeen <= 1'b0;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        quarter <= quarter + 2'd1;
        if (quarter == 2'd3)
          bitIdx <= (bitOp && bitIdx != LAST_BIT) ? bitIdx + 4'd1 : 4'd0;
        if (curOp == OP_WRITE && quarter == 2'd1 && bitIdx == LAST_BIT && sdaIn)
          nackSeen <= 1'b1;
      end
      if (opEnd) begin
        if (step == STEP_STOP)  doneReg <= 1'b1;
        else if (nackSeen)      step    <= STEP_STOP;
        else                    step    <= step + 4'd1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.txLoad   = tick && curOp == OP_WRITE && quarter == 2'd0 && bitIdx == 4'd0;
    strb.txSel    = (step == 4'd1) ? 2'd0 : (step == 4'd2) ? 2'd1 : 2'd2;
    strb.txShift  = tick && curOp == OP_WRITE && quarter == 2'd3 && bitIdx < LAST_BIT;
    strb.rxShift  = tick && curOp == OP_READ && quarter == 2'd1 && bitIdx < LAST_BIT;
    strb.byteDone = opEnd && curOp == OP_READ;
    strb.byteIdx  = 3'(step - STEP_FIRST_RD);
    strb.finish   = opEnd && step == STEP_STOP;
    strb.linkOk   = !nackSeen;
  end

  // quarter phases: clock is high in quarters 1 and 2 of every bit
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    if (running) begin
      unique case (curOp)
        OP_START: begin
          sclLow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaLow = quarter[1];
        end
        OP_STOP: begin
          sclLow = (quarter == 2'd0);
          sdaLow = !quarter[1];
        end
        OP_WRITE: begin
          sclLow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaLow = (bitIdx < LAST_BIT) ? !txBit : 1'b0;
        end
        default: begin
          sclLow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaLow = (bitIdx == LAST_BIT) && (step != STEP_LAST_RD);
        end
      endcase
    end
  end

  assign busy = running;
  assign done = doneReg;

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);
  assert_soft_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !autoMode |-> (!busy && !done));
  assert_bus_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclLow && !sdaLow));
  assert_sda_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && bitOp && quarter == 2'd2) |-> $stable(sdaLow));
endmodule

// File: rtl/seeid_datapath.sv
module seeid_datapath
  import seeid_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        autoMode,
  input  strobe_t     strb,
  input  logic        sdaIn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  output logic        txBit,
  output logic [15:0] vendorId,
  output logic [15:0] subsysId,
  output logic        loadOk
);
  localparam int VEN_LO = 0;
  localparam int VEN_HI = 1;
  localparam int SUB_LO = 2;
  localparam int SUB_HI = 3;

  logic [7:0] txReg;
  logic [7:0] rxReg;
  logic [7:0] sumReg;
  logic [7:0] stage [ID_BYTES];
  logic       imageGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strb.txLoad) begin
      unique case (strb.txSel)
        2'd0:    txReg <= {DEV_ADDR, 1'b0};
        2'd1:    txReg <= BASE_ADDR;
        default: txReg <= {DEV_ADDR, 1'b1};
      endcase
    end else if (strb.txShift) begin
      txReg <= {txReg[6:0], 1'b0};
    end
  end
  assign txBit = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      sumReg <= SUM_SEED;
    end else begin
      if (strb.rxShift)  rxReg  <= {rxReg[6:0], sdaIn};
      if (strb.byteDone) sumReg <= sumReg + rxReg;
    end
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stage[g] <= '0;
      else if (strb.byteDone && strb.byteIdx == 3'(g))
        stage[g] <= rxReg;
    end
  end

  assign imageGood = strb.linkOk && (sumReg == 8'h00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vendorId <= '0;
      subsysId <= '0;
      loadOk   <= 1'b0;
    end else if (autoMode) begin
      if (strb.finish) begin
        if (imageGood) begin
          vendorId <= {stage[VEN_HI], stage[VEN_LO]};
          subsysId <= {stage[SUB_HI], stage[SUB_LO]};
          loadOk   <= 1'b1;
        end else begin
          vendorId <= '0;
          subsysId <= '0;
          loadOk   <= 1'b0;
        end
      end
    end else if (wrEn) begin
      if (wrSel) subsysId <= wrData;
      else       vendorId <= wrData;
    end
  end

  assert_ids_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !strb.finish) |=> ($stable(vendorId) && $stable(subsysId)));
  assert_fail_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && strb.finish && !strb.linkOk) |=> (vendorId == 16'h0 && subsysId == 16'h0 && !loadOk));
endmodule

// File: rtl/seeprom_id_loader.sv
module seeprom_id_loader
  import seeid_pkg::*;
#(
  parameter int QTR_CYC = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  strapN,
  input  logic        dataPinIn,
  input  logic [1:0]  fwDriveLow,
  output logic [1:0]  pinDriveLow,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  output logic [15:0] vendorId,
  output logic [15:0] subsysId,
  output logic        busy,
  output logic        done,
  output logic        loadOk
);
  logic    autoMode;
  strobe_t strb;
  logic    txBit;
  logic    sclLow;
  logic    sdaLow;

  // straps are only looked at while reset is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) autoMode <= (strapN == 2'b00);
  end

  seeid_ctrl #(.QTR_CYC(QTR_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .autoMode (autoMode),
    .sdaIn    (dataPinIn),
    .txBit    (txBit),
    .strb     (strb),
    .sclLow   (sclLow),
    .sdaLow   (sdaLow),
    .busy     (busy),
    .done     (done)
  );

  seeid_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .autoMode (autoMode),
    .strb     (strb),
    .sdaIn    (dataPinIn),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .txBit    (txBit),
    .vendorId (vendorId),
    .subsysId (subsysId),
    .loadOk   (loadOk)
  );

  assign pinDriveLow = autoMode ? {sdaLow, sclLow} : fwDriveLow;
endmodule

// File: tb/seeprom_id_loader_bench.sv
`timescale 1ns/1ps
module seeprom_id_loader_bench;
  localparam int QTR = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strapN = 2'b00;
  logic [1:0]  fwDriveLow = 2'b00;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0]  pinDriveLow;
  logic [15:0] vendorId, subsysId;
  logic        busy, done, loadOk;
  logic        sclLine, sdaLine;

  int nChecks = 0;
  int nFail = 0;

  // EEPROM model state
  logic       slvReset = 1'b1;
  logic       slvPresent = 1'b1;
  logic       slvNackWord = 1'b0;
  logic       slvPull = 1'b0;
  logic [7:0] eeMem [5];
  int         sPhase, sBit, nAddr, nRead;
  logic [7:0] sShift, sPtr, logWord, curByte;
  logic [7:0] logAddr [2];
  logic [4:0] ackPat;
  logic       sRw, pScl, pSda, obsScl, obsSda;

  assign sclLine = !pinDriveLow[0];
  assign sdaLine = !pinDriveLow[1] && !slvPull;

  always #2.5 clk = ~clk;

  seeprom_id_loader #(.QTR_CYC(QTR)) u_seeprom_id_loader (
    .clk(clk), .rstN(rstN), .strapN(strapN), .dataPinIn(sdaLine),
    .fwDriveLow(fwDriveLow), .pinDriveLow(pinDriveLow),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .vendorId(vendorId), .subsysId(subsysId),
    .busy(busy), .done(done), .loadOk(loadOk)
  );

  function automatic logic [7:0] romByte(input logic [7:0] p);
    if (p >= 8'hFB) return eeMem[p - 8'hFB];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (slvReset) begin
      sPhase = 0; sBit = 0; slvPull = 1'b0; pScl = 1'b1; pSda = 1'b1;
      nAddr = 0; nRead = 0; ackPat = '0; logWord = '0; sRw = 1'b0;
      logAddr[0] = '0; logAddr[1] = '0; sPtr = '0; sShift = '0;
    end else begin
      obsScl = sclLine;
      obsSda = sdaLine;
      if (pScl && obsScl && pSda && !obsSda) begin
        sPhase = 1; sBit = 0; slvPull = 1'b0;
      end else if (pScl && obsScl && !pSda && obsSda) begin
        sPhase = 0; slvPull = 1'b0;
      end else if (!pScl && obsScl) begin
        if ((sPhase == 1 || sPhase == 2) && sBit < 8) sShift = {sShift[6:0], obsSda};
        if (sPhase == 3 && sBit == 8) begin ackPat = {ackPat[3:0], !obsSda}; nRead++; end
        sBit++;
      end else if (pScl && !obsScl) begin
        case (sPhase)
          1: if (sBit == 8) begin
               if (nAddr < 2) logAddr[nAddr] = sShift;
               nAddr++;
               if (slvPresent && sShift[7:1] == 7'h50) begin slvPull = 1'b1; sRw = sShift[0]; end
               else sPhase = 4;
             end else if (sBit == 9) begin
               slvPull = 1'b0; sBit = 0;
               if (sRw) begin sPhase = 3; curByte = romByte(sPtr); slvPull = !curByte[7]; end
               else sPhase = 2;
             end
          2: if (sBit == 8) begin
               sPtr = sShift; logWord = sShift;
               if (slvNackWord) begin slvPull = 1'b0; sPhase = 4; end
               else slvPull = 1'b1;
             end else if (sBit == 9) begin
               slvPull = 1'b0; sBit = 0;
             end
          3: if (sBit < 8) begin
               curByte = romByte(sPtr); slvPull = !curByte[7 - sBit];
             end else if (sBit == 8) begin
               slvPull = 1'b0;
             end else begin
               if (ackPat[0]) begin
                 sPtr = sPtr + 8'd1; sBit = 0; curByte = romByte(sPtr); slvPull = !curByte[7];
               end else begin
                 sPhase = 4; slvPull = 1'b0;
               end
             end
          default: ;
        endcase
      end
      pScl = obsScl;
      pSda = obsSda;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {ok, subsystem ID, vendor ID}
  function automatic logic [32:0] predict(input logic [7:0] b0, b1, b2, b3, ck,
                                          input bit present, input bit nackW);
    logic [7:0] s;
    s = 8'h55 + b0 + b1 + b2 + b3 + ck;
    if (present && !nackW && s == 8'h00) return {1'b1, b3, b2, b1, b0};
    return '0;
  endfunction

  task automatic applyReset(input logic [1:0] straps);
    @(negedge clk);
    rstN = 1'b0; strapN = straps; slvReset = 1'b1; wrEn = 1'b0; fwDriveLow = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1; slvReset = 1'b0;
  endtask

  task automatic runAuto(input logic [7:0] b0, b1, b2, b3, ck,
                         input bit present, input bit nackW, input bit flip);
    logic [32:0] exp;
    int cyc, hiRun, firstHi;
    string tag;
    exp = predict(b0, b1, b2, b3, ck, present, nackW);
    eeMem[0] = b0; eeMem[1] = b1; eeMem[2] = b2; eeMem[3] = b3; eeMem[4] = ck;
    slvPresent = present; slvNackWord = nackW;
    applyReset(2'b00);
    if (flip) strapN = 2'b01;
    chk("R4 busy after reset", {31'd0, busy}, 32'd1);
    chk("R9 ids zero while busy", {vendorId, subsysId}, 32'd0);
    wrEn = 1'b1; wrSel = $urandom_range(0, 1); wrData = 16'($urandom) | 16'h1;
    cyc = 0; hiRun = 0; firstHi = -1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      wrEn = 1'b0;
      cyc++;
      if (sclLine) hiRun++;
      else if (hiRun > 0 && firstHi < 0) firstHi = hiRun;
      if (busy && (vendorId != 0 || subsysId != 0)) chk("R9 ids nonzero while busy", {vendorId, subsysId}, 32'd0);
    end
    chk("R4 sequence finished", {31'd0, done}, 32'd1);
    chk("R4 busy low at end", {31'd0, busy}, 32'd0);
    chk("R11 clock high width", 32'(firstHi), 32'(2 * QTR));
    tag = !present ? "R8 absent" : nackW ? "R8 word nack" : exp[32] ? "R6 mapping" : "R7 bad sum";
    chk({tag, " vendor"}, {16'd0, vendorId}, {16'd0, exp[15:0]});
    chk({tag, " subsys"}, {16'd0, subsysId}, {16'd0, exp[31:16]});
    chk("R7 loadOk", {31'd0, loadOk}, {31'd0, exp[32]});
    chk("R10 pins released", {30'd0, pinDriveLow}, 32'd0);
    if (present && !nackW) begin
      chk("R5 device write byte", {24'd0, logAddr[0]}, 32'hA0);
      chk("R5 word address", {24'd0, logWord}, 32'hFB);
      chk("R5 device read byte", {24'd0, logAddr[1]}, 32'hA1);
      chk("R5 ack pattern", {27'd0, ackPat}, 32'b11110);
      chk("R5 reads", 32'(nRead), 32'd5);
    end else begin
      chk("R8 no data read", 32'(nRead), 32'd0);
    end
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = ~vendorId;
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b1; wrData = ~subsysId;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 write ignored vendor", {16'd0, vendorId}, {16'd0, exp[15:0]});
    chk("R9 write ignored subsys", {16'd0, subsysId}, {16'd0, exp[31:16]});
    chk("R4 done held", {31'd0, done}, 32'd1);
    if (flip) chk("R1 strap change ignored", {31'd0, loadOk}, {31'd0, exp[32]});
  endtask

  task automatic runSoft(input logic [1:0] straps);
    logic [15:0] expVen, expSub;
    applyReset(straps);
    strapN = 2'b00;
    chk("R3 reset vendor", {16'd0, vendorId}, 32'd0);
    chk("R3 reset subsys", {16'd0, subsysId}, 32'd0);
    chk("R2 busy/done idle", {30'd0, busy, done}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      fwDriveLow = 2'(i);
      @(negedge clk);
      chk("R2 pin mirror", {30'd0, pinDriveLow}, 32'(i));
    end
    fwDriveLow = 2'b00;
    expVen = '0; expSub = '0;
    for (int i = 0; i < 8; i++) begin
      wrEn = 1'b1; wrSel = $urandom_range(0, 1); wrData = 16'($urandom);
      if (wrSel) expSub = wrData; else expVen = wrData;
      @(negedge clk);
      wrEn = 1'b0;
      chk("R3 write vendor", {16'd0, vendorId}, {16'd0, expVen});
      chk("R3 write subsys", {16'd0, subsysId}, {16'd0, expSub});
    end
    repeat (50) @(negedge clk);
    chk("R1 stays software mode", {30'd0, busy, done}, 32'd0);
    chk("R1 stays software pins", {30'd0, pinDriveLow}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1, r2, r3, ck;
    void'($urandom(32'd7341));
    runSoft(2'b10);
    runAuto(8'h34, 8'h12, 8'h78, 8'h56, 8'(8'h00 - (8'h55 + 8'h34 + 8'h12 + 8'h78 + 8'h56)), 1, 0, 0);
    runAuto(8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 1, 0, 1);
    runAuto(8'h00, 8'h00, 8'h00, 8'h00, 8'hAB, 1, 0, 0);
    runAuto(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h5A, 1, 0, 1);
    runAuto(8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 0, 0, 0);
    runAuto(8'h11, 8'h22, 8'h33, 8'h44, 8'(8'h00 - (8'h55 + 8'h11 + 8'h22 + 8'h33 + 8'h44)), 1, 1, 0);
    runSoft(2'b11);
    for (int i = 0; i < 20; i++) begin
      r0 = 8'($urandom); r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
      ck = 8'h00 - (8'h55 + r0 + r1 + r2 + r3);
      if ($urandom_range(0, 1) == 1) ck = ck ^ (8'($urandom_range(1, 255)));
      runAuto(r0, r1, r2, r3, ck, 1, 0, bit'(i % 3 == 0));
    end
    runSoft(2'b01);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule